// File: doc/BRIEF.md
# Instruction-Steered Sample Router

This block sits behind a filter compute engine and sends each result sample to one destination. The destination is chosen per sample by an 11-bit control field that travels with the sample. The field is the slice of the filter instruction word covering instruction bits 28 down to 18. The possible destinations are:

- a recirculation port back into the engine, for cascading filter passes;
- a direct cascade output;
- a small FIFO that releases its entries at an evenly spaced rate toward the AGC outputs.

On the recirculation port the block can substitute magnitude and a scaled phase derivative for the I/Q pair. Both come from an external Cartesian-to-polar stage.

The same field also carries two flags. One is a start-of-frame flag for the serial output section. The other is an AGC update request with a gain-select bit. Each flag turns into a one-cycle pulse that accompanies the routed sample. The AGC loop arithmetic, the filter engine and the coordinate converter sit outside this block.

Top module: `sample_router`

## Requirements
- R1: Field bits 8:7 (instruction bits 26:25) select the path. Code 00 puts the sample on the recirculation port (`fb_*`) one clock later. `fb_step` then equals field bits 4:0 (instruction bits 22:18).
- R2: On path 00, field bit 10 (instruction bit 28) selects the polar form. When it is 1, `fb_i` carries `in_mag` and `fb_q` carries the phase derivative. When it is 0, the port carries `in_i`/`in_q`.
- R3: The phase derivative is (phase minus the phase of the previous valid sample) modulo 2^DW, shifted left by `dphi_shift`. The shift codes 0, 1, 2, 3 scale by x1, x2, x4, x8, and the result is truncated to DW bits.
- R4: The first valid sample after reset yields a phase derivative of zero.
- R5: Path code 10 puts `in_i`/`in_q` on the cascade port (`cas_*`) one clock later.
- R6: Path codes 01 and 11 push the sample into the FIFO. Samples leave in push order on `agc_*`. `agc_lane` is 0 for code 01 (first output pair) and 1 for code 11 (second output pair).
- R7: A down-counting timer reloads from `pace_period` whenever it reaches zero. One entry is released on each zero while the FIFO holds data. Under a backlog, releases are exactly `pace_period`+1 cycles apart.
- R8: A push that arrives while the FIFO holds DEPTH entries is dropped. Fullness is judged before that cycle's release. The drop sets the sticky flag `ovf`.
- R9: `ovf_clear` clears `ovf` at the next clock edge.
- R10: `agc_upd` pulses one clock after a valid sample on path 01 whose field bit 6 (instruction bit 24) is 1. `agc_gain` carries that sample's field bit 5 (instruction bit 23) in the same cycle. Bit 6 has no effect on any other path.
- R11: `frame_start` pulses for one clock after any valid sample whose field bit 9 (instruction bit 27) is 1, whatever its path.
- R12: Each valid sample reaches exactly one of the recirculation port, the cascade port or the FIFO. Without `in_valid`, no output valid, pulse or push occurs.
- R13: After reset all valid outputs, pulses and `ovf` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Result sample valid |
| in_i | input | DW | Result I |
| in_q | input | DW | Result Q |
| in_dest | input | 11 | Destination field (instruction bits 28:18) |
| in_mag | input | DW | Magnitude from polar stage |
| in_phase | input | DW | Phase from polar stage |
| dphi_shift | input | 2 | Phase derivative scale code |
| pace_period | input | TIMER_W | Release timer reload value |
| ovf_clear | input | 1 | Clears the overflow flag |
| fb_valid | output | 1 | Recirculation sample valid |
| fb_i | output | DW | Recirculation I lane (or magnitude) |
| fb_q | output | DW | Recirculation Q lane (or phase derivative) |
| fb_step | output | 5 | Filter sequence step of the recirculated sample |
| cas_valid | output | 1 | Cascade sample valid |
| cas_i | output | DW | Cascade I |
| cas_q | output | DW | Cascade Q |
| agc_valid | output | 1 | Paced FIFO release valid |
| agc_i | output | DW | Released I |
| agc_q | output | DW | Released Q |
| agc_lane | output | 1 | 0: first output pair, 1: second output pair |
| agc_upd | output | 1 | AGC loop update pulse |
| agc_gain | output | 1 | AGC loop gain select, qualified by agc_upd |
| frame_start | output | 1 | Serial output frame start strobe |
| ovf | output | 1 | Sticky FIFO overflow flag |

## Verification
The recirculation port, the cascade port, the AGC update pulse and the frame strobe all pass through one register, so the bench drives each sample half a cycle before an edge and reads these outputs just after that edge. A FIFO release appears one clock after the timer edge on which it is popped. That edge depends on the free-running timer phase, so released samples are logged on falling edges together with a cycle count, and the bench checks their order, lane and spacing rather than an absolute cycle. Overflow is provoked with a long reload value that holds releases off, and the dropped entries are then shown to be absent when the FIFO drains at full rate.

// File: rtl/router_pkg.sv
package router_pkg;

   typedef enum logic [1:0] {
      PATH_LOOP   = 2'b00,
      PATH_PAIR_A = 2'b01,
      PATH_DIRECT = 2'b10,
      PATH_PAIR_B = 2'b11
   } route_t;

   // 11-bit steering field, MSB first (instruction bits 28..18)
   typedef struct packed {
      logic       polar;
      logic       frame;
      route_t     path;
      logic       upd;
      logic       gain;
      logic [4:0] step;
   } steer_t;

   localparam int STEER_W = $bits(steer_t);

endpackage

// File: rtl/phase_delta.sv
module phase_delta #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] phase,
   input  logic [1:0]   shift,
   output logic [W-1:0] delta
);
   logic [W-1:0] prev_q;
   logic         seen_q;
   logic [W-1:0] diff;

   assign diff = seen_q ? (phase - prev_q) : '0;

   always_comb begin
      unique case (shift)
         2'd0:    delta = diff;
         2'd1:    delta = diff << 1;
         2'd2:    delta = diff << 2;
         default: delta = diff << 3;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         seen_q <= 1'b0;
      end else if (en) begin
         prev_q <= phase;
         seen_q <= 1'b1;
      end
   end

   // R4: the history flag is only ever set by an accepted sample
   a_r4_seen_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(seen_q) |-> $past(en));

endmodule

// File: rtl/pace_fifo.sv
module pace_fifo #(
   parameter int W       = 33,
   parameter int DEPTH   = 8,
   parameter int TIMER_W = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               push,
   input  logic [W-1:0]       push_data,
   input  logic [TIMER_W-1:0] period,
   input  logic               ovf_clear,
   output logic               pop_valid,
   output logic [W-1:0]       pop_data,
   output logic               ovf
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   initial begin : p_param_chk
      assert (DEPTH >= 8) else $error("pace_fifo: DEPTH must be at least 8");
      assert (TIMER_W >= 1) else $error("pace_fifo: TIMER_W must be positive");
   end

   logic [W-1:0]       mem [DEPTH];
   logic [AW-1:0]      wr_ptr, rd_ptr;
   logic [CW-1:0]      count;
   logic [TIMER_W-1:0] timer;
   logic               full, accept, tick, pop;

   assign full   = (count == CW'(DEPTH));
   assign accept = push && !full;
   assign tick   = (timer == '0);
   assign pop    = tick && (count != '0);

   for (genvar e = 0; e < DEPTH; e++) begin : g_slot
      always_ff @(posedge clk) begin
         if (accept && wr_ptr == AW'(e)) mem[e] <= push_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr    <= '0;
         rd_ptr    <= '0;
         count     <= '0;
         timer     <= '0;
         pop_valid <= 1'b0;
         pop_data  <= '0;
         ovf       <= 1'b0;
      end else begin
         timer     <= tick ? period : timer - 1'b1;
         count     <= count + CW'(accept) - CW'(pop);
         pop_valid <= pop;
         if (accept) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         if (pop) begin
            rd_ptr   <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            pop_data <= mem[rd_ptr];
         end
         if (push && full)   ovf <= 1'b1;
         else if (ovf_clear) ovf <= 1'b0;
      end
   end

   a_r7_release_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
      pop_valid |-> $past(timer) == '0);
   a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop_valid |-> $past(count) != '0);
   a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   a_r8_drop_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      push && full |=> ovf);
   a_r9_clear_flag: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_clear && !(push && full) |=> !ovf);

endmodule

// File: rtl/sample_router.sv
module sample_router
   import router_pkg::*;
#(
   parameter int DW         = 16,
   parameter int FIFO_DEPTH = 8,
   parameter int TIMER_W    = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [DW-1:0]      in_i,
   input  logic [DW-1:0]      in_q,
   input  logic [10:0]        in_dest,
   input  logic [DW-1:0]      in_mag,
   input  logic [DW-1:0]      in_phase,
   input  logic [1:0]         dphi_shift,
   input  logic [TIMER_W-1:0] pace_period,
   input  logic               ovf_clear,
   output logic               fb_valid,
   output logic [DW-1:0]      fb_i,
   output logic [DW-1:0]      fb_q,
   output logic [4:0]         fb_step,
   output logic               cas_valid,
   output logic [DW-1:0]      cas_i,
   output logic [DW-1:0]      cas_q,
   output logic               agc_valid,
   output logic [DW-1:0]      agc_i,
   output logic [DW-1:0]      agc_q,
   output logic               agc_lane,
   output logic               agc_upd,
   output logic               agc_gain,
   output logic               frame_start,
   output logic               ovf
);
   localparam int ENTRY_W = 2 * DW + 1;

   initial begin : p_param_chk
      assert (STEER_W == 11) else $error("sample_router: steering field must be 11 bits");
      assert (DW >= 2) else $error("sample_router: DW too small");
   end

   steer_t             st;
   logic [DW-1:0]      dphi;
   logic               to_loop, to_direct, to_fifo;
   logic [ENTRY_W-1:0] pop_word;

   assign st        = steer_t'(in_dest);
   assign to_loop   = in_valid && (st.path == PATH_LOOP);
   assign to_direct = in_valid && (st.path == PATH_DIRECT);
   assign to_fifo   = in_valid && st.path[0];

   phase_delta #(.W(DW)) u_delta (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (in_valid),
      .phase (in_phase),
      .shift (dphi_shift),
      .delta (dphi)
   );

   pace_fifo #(.W(ENTRY_W), .DEPTH(FIFO_DEPTH), .TIMER_W(TIMER_W)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (to_fifo),
      .push_data ({st.path[1], in_i, in_q}),
      .period    (pace_period),
      .ovf_clear (ovf_clear),
      .pop_valid (agc_valid),
      .pop_data  (pop_word),
      .ovf       (ovf)
   );

   assign agc_lane = pop_word[ENTRY_W-1];
   assign agc_i    = pop_word[2*DW-1:DW];
   assign agc_q    = pop_word[DW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fb_valid    <= 1'b0;
         fb_i        <= '0;
         fb_q        <= '0;
         fb_step     <= '0;
         cas_valid   <= 1'b0;
         cas_i       <= '0;
         cas_q       <= '0;
         agc_upd     <= 1'b0;
         agc_gain    <= 1'b0;
         frame_start <= 1'b0;
      end else begin
         fb_valid    <= to_loop;
         cas_valid   <= to_direct;
         frame_start <= in_valid && st.frame;
         agc_upd     <= in_valid && (st.path == PATH_PAIR_A) && st.upd;
         agc_gain    <= in_valid && (st.path == PATH_PAIR_A) && st.upd && st.gain;
         if (to_loop) begin
            fb_i    <= st.polar ? in_mag : in_i;
            fb_q    <= st.polar ? dphi   : in_q;
            fb_step <= st.step;
         end
         if (to_direct) begin
            cas_i <= in_i;
            cas_q <= in_q;
         end
      end
   end

   a_r1_loop_route: assert property (@(posedge clk) disable iff (!rst_n)
      to_loop |=> fb_valid && fb_step == $past(in_dest[4:0]));
   a_r5_direct_route: assert property (@(posedge clk) disable iff (!rst_n)
      to_direct |=> cas_valid && cas_i == $past(in_i) && cas_q == $past(in_q));
   a_r10_upd_gate: assert property (@(posedge clk) disable iff (!rst_n)
      agc_upd |-> $past(in_valid) && $past(in_dest[8:7]) == 2'b01);
   a_r11_frame_source: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> $past(in_valid) && $past(in_dest[9]));
   a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !fb_valid && !cas_valid && !agc_upd && !frame_start);

endmodule

// File: tb/sample_router_bench.sv
module sample_router_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 16;

   typedef struct packed {
      logic [10:0] dest;
      logic [15:0] i, q, mag, ph;
      logic [1:0]  sh;
      logic        e_fb, e_cas, e_frame;
      logic [15:0] e_a, e_b;
      logic [4:0]  e_step;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VEC [NV] = '{
      '{11'h403, 16'h0000, 16'h0000, 16'h0700, 16'h1000, 2'd2, 1'b1, 1'b0, 1'b0, 16'h0700, 16'h0000, 5'd3},
      '{11'h407, 16'h0000, 16'h0000, 16'h0010, 16'h1010, 2'd0, 1'b1, 1'b0, 1'b0, 16'h0010, 16'h0010, 5'd7},
      '{11'h401, 16'h0000, 16'h0000, 16'h7FFF, 16'h0FF0, 2'd1, 1'b1, 1'b0, 1'b0, 16'h7FFF, 16'hFFC0, 5'd1},
      '{11'h400, 16'h0000, 16'h0000, 16'h0002, 16'hFFF0, 2'd0, 1'b1, 1'b0, 1'b0, 16'h0002, 16'hF000, 5'd0},
      '{11'h41E, 16'h0000, 16'h0000, 16'h0003, 16'h0010, 2'd3, 1'b1, 1'b0, 1'b0, 16'h0003, 16'h0100, 5'd30},
      '{11'h340, 16'h1234, 16'h8001, 16'h0000, 16'h0020, 2'd0, 1'b0, 1'b1, 1'b1, 16'h1234, 16'h8001, 5'd0},
      '{11'h25F, 16'h7FFF, 16'h8000, 16'h0000, 16'h0020, 2'd0, 1'b1, 1'b0, 1'b1, 16'h7FFF, 16'h8000, 5'd31},
      '{11'h405, 16'h0000, 16'h0000, 16'h0001, 16'h0030, 2'd2, 1'b1, 1'b0, 1'b0, 16'h0001, 16'h0040, 5'd5}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic in_valid = 1'b0, ovf_clear = 1'b0;
   logic [DW-1:0] in_i = '0, in_q = '0, in_mag = '0, in_phase = '0;
   logic [10:0] in_dest = '0;
   logic [1:0] dphi_shift = '0;
   logic [11:0] pace_period = 12'd4;
   logic fb_valid, cas_valid, agc_valid, agc_lane, agc_upd, agc_gain, frame_start, ovf;
   logic [DW-1:0] fb_i, fb_q, cas_i, cas_q, agc_i, agc_q;
   logic [4:0] fb_step;

   sample_router u_sample_router (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
      .in_dest(in_dest), .in_mag(in_mag), .in_phase(in_phase), .dphi_shift(dphi_shift),
      .pace_period(pace_period), .ovf_clear(ovf_clear),
      .fb_valid(fb_valid), .fb_i(fb_i), .fb_q(fb_q), .fb_step(fb_step),
      .cas_valid(cas_valid), .cas_i(cas_i), .cas_q(cas_q),
      .agc_valid(agc_valid), .agc_i(agc_i), .agc_q(agc_q), .agc_lane(agc_lane),
      .agc_upd(agc_upd), .agc_gain(agc_gain), .frame_start(frame_start), .ovf(ovf)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int total = 0, bad = 0, cyc = 0, nrec = 0;
   logic [15:0] rec_i [16];
   logic [15:0] rec_q [16];
   logic        rec_lane [16];
   int          rec_cyc [16];

   always @(posedge clk) cyc <= cyc + 1;
   always @(negedge clk) begin
      if (agc_valid && nrec < 16) begin
         rec_i[nrec] = agc_i; rec_q[nrec] = agc_q;
         rec_lane[nrec] = agc_lane; rec_cyc[nrec] = cyc;
         nrec = nrec + 1;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [10:0] d, input logic [15:0] i, input logic [15:0] q,
                        input logic [15:0] m, input logic [15:0] p, input logic [1:0] s);
      @(negedge clk);
      in_valid = 1'b1; in_dest = d; in_i = i; in_q = q;
      in_mag = m; in_phase = p; dphi_shift = s;
      @(posedge clk); #1;
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      in_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 200000);
      bad++; total++;
      $display("FAIL R0 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R13 reset state
      chk("R13 valids", {fb_valid, cas_valid, agc_valid, agc_upd, frame_start, ovf}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R13 after release", {fb_valid, cas_valid, agc_valid, agc_upd, frame_start, ovf}, 0);

      // table walk: R1 R2 R3 R4 R5 R10 R11 R12
      for (int k = 0; k < NV; k++) begin
         drive(VEC[k].dest, VEC[k].i, VEC[k].q, VEC[k].mag, VEC[k].ph, VEC[k].sh);
         chk($sformatf("R12 v%0d fb_valid", k), fb_valid, VEC[k].e_fb);
         chk($sformatf("R12 v%0d cas_valid", k), cas_valid, VEC[k].e_cas);
         chk($sformatf("R11 v%0d frame", k), frame_start, VEC[k].e_frame);
         chk($sformatf("R10 v%0d upd ignored", k), agc_upd, 0);
         if (VEC[k].e_fb) begin
            chk($sformatf("R2 v%0d fb_i", k), fb_i, VEC[k].e_a);
            chk($sformatf("R3 R4 v%0d fb_q", k), fb_q, VEC[k].e_b);
            chk($sformatf("R1 v%0d step", k), fb_step, VEC[k].e_step);
         end else begin
            chk($sformatf("R5 v%0d cas", k), {cas_i, cas_q}, {VEC[k].e_a, VEC[k].e_b});
         end
      end

      // R12: field set but no valid
      @(negedge clk);
      in_valid = 1'b0; in_dest = 11'h2C0;
      @(posedge clk); #1;
      chk("R12 idle quiet", {fb_valid, cas_valid, agc_upd, frame_start}, 0);
      idle(20);
      chk("R12 no stray push", nrec, 0);

      // FIFO path with pacing 4: R6 R7 R10 R11
      drive(11'h2E0, 16'h0A0A, 16'h0B0B, 0, 0, 0);
      chk("R10 upd pair A", {agc_upd, agc_gain}, 2'b11);
      chk("R11 frame on fifo path", frame_start, 1);
      drive(11'h1C0, 16'h0C0C, 16'h0D0D, 0, 0, 0);
      chk("R10 upd ignored pair B", agc_upd, 0);
      drive(11'h0C0, 16'h0E0E, 16'h0F0F, 0, 0, 0);
      chk("R10 upd gain low", {agc_upd, agc_gain}, 2'b10);
      idle(30);
      chk("R6 release count", nrec, 3);
      chk("R6 first", {rec_lane[0], rec_i[0], rec_q[0]}, {1'b0, 16'h0A0A, 16'h0B0B});
      chk("R6 second lane B", {rec_lane[1], rec_i[1], rec_q[1]}, {1'b1, 16'h0C0C, 16'h0D0D});
      chk("R6 third", {rec_lane[2], rec_i[2], rec_q[2]}, {1'b0, 16'h0E0E, 16'h0F0F});
      chk("R7 spacing 1", rec_cyc[1] - rec_cyc[0], 5);
      chk("R7 spacing 2", rec_cyc[2] - rec_cyc[1], 5);

      // overflow: R8 R9
      pace_period = 12'd1000;
      idle(10);
      for (int k = 0; k < 10; k++)
         drive(11'h080, 16'(k), 16'(~k), 0, 0, 0);
      chk("R8 overflow flagged", ovf, 1);
      chk("R7 held off", nrec, 3);
      @(negedge clk);
      in_valid = 1'b0; ovf_clear = 1'b1;
      @(posedge clk); #1;
      ovf_clear = 1'b0;
      chk("R9 overflow cleared", ovf, 0);
      pace_period = 12'd0;
      idle(1100);
      chk("R8 kept entries only", nrec, 11);
      for (int k = 0; k < 8; k++)
         chk($sformatf("R8 drain %0d", k), {rec_i[3+k], rec_q[3+k]}, {16'(k), 16'(~k)});
      chk("R9 flag stays clear", ovf, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule